// File: doc/BRIEF.md
# Dual-Set Receive Packet Buffer

This block buffers the OUT and SETUP packets of one USB endpoint on the device side. It sits between the serial engine, which pushes received bytes one per cycle and then reports whether the packet arrived intact, and a local CPU, which pulls completed packets out a byte at a time. The storage is split into two data sets, so a new packet can land in one set while the CPU is still draining the other.

An intact packet commits its set: the set is flagged valid, its byte count is latched, and filling moves to the other set. A failed packet rewinds the write pointer to the write marker, which holds the start address of the set being filled, so the retry overwrites the partial data. When both sets hold unread packets the endpoint drops its ready output, and the protocol layer refuses (NAKs) further packets. The CPU frees a drained set by raising a self-clearing advance request. For non-isochronous endpoints a manual mode hands the commit and rewind decisions to firmware.

The per-set capacity comes from a 2-bit size code, an isochronous flag and an extended-size flag, and is clamped to the storage parameter `MAXB`. The configuration is static: it may only change while both sets are empty, followed by a reset.

Top module: `rx_dual_set_fifo`

## Requirements
- R1: After reset both sets are empty (`set_valid` = 2'b00), `usb_ready` = 1, `rd_count` = 0, `adv_busy` = 0, and both pending flags are 0.
- R2: A CPU read pulse is accepted when the read set is valid and fewer than `rd_count` bytes of it have been read. The byte at the read pointer then appears on `cpu_rd_data` one cycle later, and the pointer steps by one. Any other read pulse leaves `cpu_rd_data` and the pointer unchanged.
- R3: The per-set capacity is set as follows. With `cfg_iso`=0, size codes 0, 1, 2 and 3 give 16, 64, 8 and 32 bytes when `cfg_ext`=1; with `cfg_ext`=0, codes 2 and 3 both give 64. With `cfg_iso`=1, codes 0, 1, 2 and 3 give 64, 256, 512 and 1024 bytes. Any result above `MAXB` is reduced to `MAXB`.
- R4: A byte written once the set already holds its capacity is dropped and marks an overrun. A packet that ends intact after an overrun is discarded like a failed one.
- R5: An intact end with `usb_ready`=1 (automatic mode) marks the filling set valid and records its byte count. Filling moves to the other set, and the CPU receives packets in arrival order.
- R6: A failed end returns the write pointer to the write marker. No set becomes valid, and the next packet overwrites the discarded bytes.
- R7: A one-cycle `cpu_adv` pulse makes `adv_busy` read 1 in the next cycle; the bit clears itself one cycle later. At that point the valid read set is released and reading moves to the other set at offset 0. With no valid read set, the read set does not change.
- R8: While both sets are valid, `usb_ready` is 0, and byte writes and packet ends from the USB side are ignored.
- R9: When `cfg_manual`=1 and `cfg_iso`=0, a packet end only raises `pend_ok` (intact) or `pend_err` (failed or overrun). `fw_commit` then commits the set and `fw_rewind` discards it, and either one clears both pending flags. When `cfg_iso`=1, `cfg_manual` has no effect.
- R10: A zero-length intact packet commits a valid set with a count of 0, and CPU reads of that set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 2 | Capacity size code |
| cfg_iso | input | 1 | Isochronous endpoint |
| cfg_ext | input | 1 | Enables the 8- and 32-byte non-isochronous sizes |
| cfg_manual | input | 1 | Firmware controls commit and rewind (non-isochronous only) |
| usb_wr_en | input | 1 | Received byte valid |
| usb_wr_data | input | 8 | Received byte |
| usb_pkt_ok | input | 1 | Packet ended intact (pulse) |
| usb_pkt_err | input | 1 | Packet failed (pulse) |
| usb_ready | output | 1 | Filling set is free; low means refuse packets |
| fw_commit | input | 1 | Manual-mode commit (pulse) |
| fw_rewind | input | 1 | Manual-mode discard (pulse) |
| pend_ok | output | 1 | Manual mode: intact packet awaits firmware |
| pend_err | output | 1 | Manual mode: failed packet awaits firmware |
| cpu_rd_en | input | 1 | CPU byte read (pulse) |
| cpu_rd_data | output | 8 | Last byte read |
| cpu_adv | input | 1 | Request to release the read set (pulse) |
| adv_busy | output | 1 | Self-clearing advance bit |
| rd_count | output | clog2(MAXB)+1 | Byte count of the valid read set, else 0 |
| set_valid | output | 2 | Valid flag per data set |

## Verification
The bench builds the block with `MAXB` = 256. Under that setting every non-isochronous size and the two smallest isochronous sizes are reached exactly, while 512 and 1024 exercise the clamp. It sweeps all sixteen combinations of size code, isochronous flag and extended flag. For each one it overflows the set by one byte, then fills it exactly and reads every byte back against an arithmetic pattern. Short packets with the 16-byte setting cover the full-buffer refusal, rewind-and-retry, zero-length packets, advancing an empty buffer and both manual-mode paths.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Nominal per-set capacity in bytes before clamping to the storage size.
  function automatic int unsigned rxq_nominal_bytes(input logic [1:0] code,
                                                    input logic       iso,
                                                    input logic       ext);
    int unsigned n;
    if (iso) begin
      case (code)
        2'd0:    n = 64;
        2'd1:    n = 256;
        2'd2:    n = 512;
        default: n = 1024;
      endcase
    end else begin
      case (code)
        2'd0:    n = 16;
        2'd1:    n = 64;
        2'd2:    n = ext ? 8  : 64;
        default: n = ext ? 32 : 64;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/rxq_cap_dec.sv
module rxq_cap_dec #(
  parameter int unsigned MAXB = 64,
  parameter int unsigned AW   = $clog2(MAXB) + 1
) (
  input  logic [1:0]    cfg_size,
  input  logic          cfg_iso,
  input  logic          cfg_ext,
  output logic [AW-1:0] cap
);
  import rxq_pkg::*;

  int unsigned nominal;

  always_comb begin
    nominal = rxq_nominal_bytes(cfg_size, cfg_iso, cfg_ext);
    if (nominal > MAXB) cap = AW'(MAXB);
    else                cap = AW'(nominal);
  end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned AW = 7,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rxq_set_track.sv
module rxq_set_track #(
  parameter int unsigned AW = 7,
  localparam int unsigned NSETS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit_en,
  input  logic                       commit_idx,
  input  logic [AW-1:0]              commit_cnt,
  input  logic                       rel_en,
  input  logic                       rel_idx,
  output logic [NSETS-1:0]           set_valid,
  output logic [NSETS-1:0][AW-1:0]   set_cnt
);

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic          valid_n;
    logic [AW-1:0] cnt_n;
    logic          hit_commit;
    logic          hit_rel;

    always_comb begin
      hit_commit = commit_en && (int'(commit_idx) == s);
      hit_rel    = rel_en    && (int'(rel_idx)    == s);
      valid_n    = set_valid[s];
      cnt_n      = set_cnt[s];
      if (hit_rel) valid_n = 1'b0;
      if (hit_commit) begin
        valid_n = 1'b1;
        cnt_n   = commit_cnt;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        set_valid[s] <= 1'b0;
        set_cnt[s]   <= '0;
      end else begin
        set_valid[s] <= valid_n;
        set_cnt[s]   <= cnt_n;
      end
    end
  end

endmodule

// File: rtl/rxq_wr_side.sv
module rxq_wr_side #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cap,
  input  logic          manual_eff,
  input  logic [1:0]    set_valid,
  input  logic          usb_wr_en,
  input  logic [7:0]    usb_wr_data,
  input  logic          usb_pkt_ok,
  input  logic          usb_pkt_err,
  input  logic          fw_commit,
  input  logic          fw_rewind,
  output logic          usb_ready,
  output logic          pend_ok,
  output logic          pend_err,
  output logic          ovr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          commit_en,
  output logic          commit_idx,
  output logic [AW-1:0] commit_cnt
);

  logic          wr_set, wr_set_n;
  logic [AW-1:0] wr_ptr, wr_ptr_n;
  logic [AW-1:0] wr_mark, wr_mark_n;
  logic          ovr_n, pend_ok_n, pend_err_n;
  logic [AW-1:0] fill;
  logic [AW-1:0] next_base;
  logic          good_end, bad_end, do_rewind, accept, room, fw_clr;

  always_comb begin
    usb_ready = !set_valid[wr_set];
    fill      = wr_ptr - wr_mark;
    room      = fill < cap;
    next_base = wr_set ? '0 : cap;
    good_end  = usb_pkt_ok && !usb_pkt_err && !ovr;
    bad_end   = usb_pkt_err || (usb_pkt_ok && ovr);
    fw_clr    = fw_commit || fw_rewind;

    if (manual_eff) begin
      commit_en = fw_commit && !fw_rewind && usb_ready;
      do_rewind = fw_rewind;
    end else begin
      commit_en = good_end && usb_ready;
      do_rewind = bad_end;
    end
    commit_idx = wr_set;
    commit_cnt = fill;

    accept    = usb_wr_en && usb_ready && !commit_en && !do_rewind;
    mem_we    = accept && room;
    mem_waddr = wr_ptr;
    mem_wdata = usb_wr_data;

    wr_set_n  = wr_set;
    wr_ptr_n  = wr_ptr;
    wr_mark_n = wr_mark;
    ovr_n     = ovr;
    if (commit_en) begin
      wr_set_n  = !wr_set;
      wr_ptr_n  = next_base;
      wr_mark_n = next_base;
      ovr_n     = 1'b0;
    end else if (do_rewind) begin
      wr_ptr_n  = wr_mark;
      ovr_n     = 1'b0;
    end else if (accept) begin
      if (room) wr_ptr_n = wr_ptr + AW'(1);
      else      ovr_n    = 1'b1;
    end

    pend_ok_n  = 1'b0;
    pend_err_n = 1'b0;
    if (manual_eff && !fw_clr) begin
      pend_ok_n  = bad_end  ? 1'b0 : (pend_ok  || good_end);
      pend_err_n = good_end ? 1'b0 : (pend_err || bad_end);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_set   <= 1'b0;
      wr_ptr   <= '0;
      wr_mark  <= '0;
      ovr      <= 1'b0;
      pend_ok  <= 1'b0;
      pend_err <= 1'b0;
    end else begin
      wr_set   <= wr_set_n;
      wr_ptr   <= wr_ptr_n;
      wr_mark  <= wr_mark_n;
      ovr      <= ovr_n;
      pend_ok  <= pend_ok_n;
      pend_err <= pend_err_n;
    end
  end

endmodule

// File: rtl/rxq_rd_side.sv
module rxq_rd_side #(
  parameter int unsigned AW = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          cap,
  input  logic [1:0]             set_valid,
  input  logic [1:0][AW-1:0]     set_cnt,
  input  logic                   cpu_rd_en,
  input  logic                   cpu_adv,
  output logic [AW-1:0]          mem_raddr,
  input  logic [7:0]             mem_rdata,
  output logic [7:0]             cpu_rd_data,
  output logic                   adv_busy,
  output logic [AW-1:0]          rd_count,
  output logic                   rel_en,
  output logic                   rel_idx
);

  logic          rd_set, rd_set_n;
  logic [AW-1:0] rd_off, rd_off_n;
  logic [7:0]    data_n;
  logic          busy_n;
  logic          cur_valid, take;
  logic [AW-1:0] cur_cnt;

  always_comb begin
    cur_valid = set_valid[rd_set];
    cur_cnt   = set_cnt[rd_set];
    rd_count  = cur_valid ? cur_cnt : '0;
    take      = cpu_rd_en && cur_valid && (rd_off < cur_cnt) && !adv_busy;
    mem_raddr = (rd_set ? cap : '0) + rd_off;

    rel_en  = adv_busy && cur_valid;
    rel_idx = rd_set;
    busy_n  = adv_busy ? 1'b0 : cpu_adv;

    rd_set_n = rd_set;
    rd_off_n = rd_off;
    data_n   = cpu_rd_data;
    if (rel_en) begin
      rd_set_n = !rd_set;
      rd_off_n = '0;
    end else if (take) begin
      rd_off_n = rd_off + AW'(1);
      data_n   = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_set      <= 1'b0;
      rd_off      <= '0;
      cpu_rd_data <= '0;
      adv_busy    <= 1'b0;
    end else begin
      rd_set      <= rd_set_n;
      rd_off      <= rd_off_n;
      cpu_rd_data <= data_n;
      adv_busy    <= busy_n;
    end
  end

endmodule

// File: rtl/rx_dual_set_fifo.sv
module rx_dual_set_fifo #(
  parameter int unsigned MAXB = 64,
  localparam int unsigned AW  = $clog2(MAXB) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_iso,
  input  logic          cfg_ext,
  input  logic          cfg_manual,
  input  logic          usb_wr_en,
  input  logic [7:0]    usb_wr_data,
  input  logic          usb_pkt_ok,
  input  logic          usb_pkt_err,
  output logic          usb_ready,
  input  logic          fw_commit,
  input  logic          fw_rewind,
  output logic          pend_ok,
  output logic          pend_err,
  input  logic          cpu_rd_en,
  output logic [7:0]    cpu_rd_data,
  input  logic          cpu_adv,
  output logic          adv_busy,
  output logic [AW-1:0] rd_count,
  output logic [1:0]    set_valid
);

  logic [AW-1:0]      cap;
  logic               manual_eff;
  logic               ovr;
  logic               mem_we;
  logic [AW-1:0]      mem_waddr, mem_raddr;
  logic [7:0]         mem_wdata, mem_rdata;
  logic               commit_en, commit_idx;
  logic [AW-1:0]      commit_cnt;
  logic               rel_en, rel_idx;
  logic [1:0][AW-1:0] set_cnt;

  assign manual_eff = cfg_manual && !cfg_iso;

  rxq_cap_dec #(.MAXB(MAXB), .AW(AW)) u_cap (
    .cfg_size (cfg_size),
    .cfg_iso  (cfg_iso),
    .cfg_ext  (cfg_ext),
    .cap      (cap)
  );

  rxq_wr_side #(.AW(AW)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap         (cap),
    .manual_eff  (manual_eff),
    .set_valid   (set_valid),
    .usb_wr_en   (usb_wr_en),
    .usb_wr_data (usb_wr_data),
    .usb_pkt_ok  (usb_pkt_ok),
    .usb_pkt_err (usb_pkt_err),
    .fw_commit   (fw_commit),
    .fw_rewind   (fw_rewind),
    .usb_ready   (usb_ready),
    .pend_ok     (pend_ok),
    .pend_err    (pend_err),
    .ovr         (ovr),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata),
    .commit_en   (commit_en),
    .commit_idx  (commit_idx),
    .commit_cnt  (commit_cnt)
  );

  rxq_store #(.AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  rxq_set_track #(.AW(AW)) u_sets (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_en  (commit_en),
    .commit_idx (commit_idx),
    .commit_cnt (commit_cnt),
    .rel_en     (rel_en),
    .rel_idx    (rel_idx),
    .set_valid  (set_valid),
    .set_cnt    (set_cnt)
  );

  rxq_rd_side #(.AW(AW)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap         (cap),
    .set_valid   (set_valid),
    .set_cnt     (set_cnt),
    .cpu_rd_en   (cpu_rd_en),
    .cpu_adv     (cpu_adv),
    .mem_raddr   (mem_raddr),
    .mem_rdata   (mem_rdata),
    .cpu_rd_data (cpu_rd_data),
    .adv_busy    (adv_busy),
    .rd_count    (rd_count),
    .rel_en      (rel_en),
    .rel_idx     (rel_idx)
  );

endmodule

// File: rtl/rx_dual_set_fifo_chk.sv
module rx_dual_set_fifo_chk #(
  parameter int unsigned MAXB = 64,
  localparam int unsigned AW  = $clog2(MAXB) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          manual_eff,
  input logic          usb_pkt_ok,
  input logic          usb_pkt_err,
  input logic          usb_ready,
  input logic          ovr,
  input logic          fw_commit,
  input logic          adv_busy,
  input logic [1:0]    set_valid,
  input logic [AW-1:0] rd_count,
  input logic [AW-1:0] cap
);

  // R7: the advance bit never stays set for two cycles
  a_r7_adv_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    adv_busy |=> !adv_busy);

  // R8: both sets full means the endpoint refuses packets
  a_r8_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid == 2'b11) |-> !usb_ready);

  // R8: with both sets free the endpoint accepts packets
  a_r8_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid == 2'b00) |-> usb_ready);

  // R5: an intact automatic end into a free set changes the valid flags
  a_r5_commit_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_eff && usb_pkt_ok && !usb_pkt_err && usb_ready && !ovr)
      |=> (set_valid != $past(set_valid)));

  // R6: a failed end commits nothing
  a_r6_err_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_eff && usb_pkt_err && !adv_busy) |=> $stable(set_valid));

  // R9: in manual mode only firmware commits
  a_r9_manual_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (manual_eff && !fw_commit && !adv_busy) |=> $stable(set_valid));

  // R2: the readable count never exceeds the set capacity
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_count <= cap);

  // R3: capacity lies between the smallest size and the storage limit
  a_r3_cap_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cap >= AW'(8)) && (cap <= AW'(MAXB)));

endmodule

bind rx_dual_set_fifo rx_dual_set_fifo_chk #(.MAXB(MAXB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .manual_eff  (manual_eff),
  .usb_pkt_ok  (usb_pkt_ok),
  .usb_pkt_err (usb_pkt_err),
  .usb_ready   (usb_ready),
  .ovr         (ovr),
  .fw_commit   (fw_commit),
  .adv_busy    (adv_busy),
  .set_valid   (set_valid),
  .rd_count    (rd_count),
  .cap         (cap)
);

// File: tb/rx_dual_set_fifo_tb.sv
module rx_dual_set_fifo_tb;
  localparam int unsigned MAXB = 256;
  localparam int unsigned AW   = $clog2(MAXB) + 1;

  logic          clk;
  logic          rst_n;
  logic [1:0]    cfg_size;
  logic          cfg_iso, cfg_ext, cfg_manual;
  logic          usb_wr_en;
  logic [7:0]    usb_wr_data;
  logic          usb_pkt_ok, usb_pkt_err, usb_ready;
  logic          fw_commit, fw_rewind, pend_ok, pend_err;
  logic          cpu_rd_en, cpu_adv, adv_busy;
  logic [7:0]    cpu_rd_data;
  logic [AW-1:0] rd_count;
  logic [1:0]    set_valid;

  int n_chk  = 0;
  int n_fail = 0;
  int last_byte;

  rx_dual_set_fifo #(.MAXB(MAXB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_iso(cfg_iso),
    .cfg_ext(cfg_ext), .cfg_manual(cfg_manual), .usb_wr_en(usb_wr_en),
    .usb_wr_data(usb_wr_data), .usb_pkt_ok(usb_pkt_ok), .usb_pkt_err(usb_pkt_err),
    .usb_ready(usb_ready), .fw_commit(fw_commit), .fw_rewind(fw_rewind),
    .pend_ok(pend_ok), .pend_err(pend_err), .cpu_rd_en(cpu_rd_en),
    .cpu_rd_data(cpu_rd_data), .cpu_adv(cpu_adv), .adv_busy(adv_busy),
    .rd_count(rd_count), .set_valid(set_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pat(input int seed, input int i);
    return (seed * 37 + i * 11 + 5) & 8'hFF;
  endfunction

  function automatic int exp_cap(input int code, input int iso, input int ext);
    int n;
    if (iso != 0) n = (code == 0) ? 64 : (128 << code);
    else if (code == 0) n = 16;
    else if (code == 1) n = 64;
    else if (ext == 0) n = 64;
    else n = (code == 2) ? 8 : 32;
    return (n > MAXB) ? MAXB : n;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  // ending: 0 intact, 1 failed, 2 none
  task automatic send_pkt(input int n, input int seed, input int ending);
    for (int i = 0; i < n; i++) begin
      usb_wr_en   = 1'b1;
      usb_wr_data = 8'(pat(seed, i));
      tick();
    end
    usb_wr_en = 1'b0;
    if (ending == 0) usb_pkt_ok = 1'b1;
    if (ending == 1) usb_pkt_err = 1'b1;
    if (ending != 2) tick();
    usb_pkt_ok  = 1'b0;
    usb_pkt_err = 1'b0;
  endtask

  task automatic read_pkt(input string req, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      cpu_rd_en = 1'b1;
      tick();
      cpu_rd_en = 1'b0;
      chk(req, int'(cpu_rd_data), pat(seed, i));
      last_byte = pat(seed, i);
    end
  endtask

  task automatic advance(input string req);
    cpu_adv = 1'b1;
    tick();
    cpu_adv = 1'b0;
    chk(req, int'(adv_busy), 1);
    tick();
    chk(req, int'(adv_busy), 0);
  endtask

  task automatic pulse_fw(input int commit);
    if (commit != 0) fw_commit = 1'b1;
    else             fw_rewind = 1'b1;
    tick();
    fw_commit = 1'b0;
    fw_rewind = 1'b0;
  endtask

  initial begin
    int c;
    rst_n = 1'b0; cfg_size = 2'd0; cfg_iso = 1'b0; cfg_ext = 1'b0; cfg_manual = 1'b0;
    usb_wr_en = 1'b0; usb_wr_data = 8'h00; usb_pkt_ok = 1'b0; usb_pkt_err = 1'b0;
    fw_commit = 1'b0; fw_rewind = 1'b0; cpu_rd_en = 1'b0; cpu_adv = 1'b0;
    last_byte = 0;
    do_reset();

    // R1 reset state
    chk("R1 set_valid", int'(set_valid), 0);
    chk("R1 usb_ready", int'(usb_ready), 1);
    chk("R1 rd_count", int'(rd_count), 0);
    chk("R1 adv_busy", int'(adv_busy), 0);
    chk("R1 pend", int'({pend_ok, pend_err}), 0);

    // R3 R4 R5 R2 sweep over all configurations
    for (int iso = 0; iso < 2; iso++) begin
      for (int ext = 0; ext < 2; ext++) begin
        for (int code = 0; code < 4; code++) begin
          cfg_iso = 1'(iso); cfg_ext = 1'(ext); cfg_size = 2'(code);
          do_reset();
          c = exp_cap(code, iso, ext);
          send_pkt(c + 1, code + 3, 0);
          chk("R4 overrun discarded", int'(set_valid), 0);
          chk("R4 ready after overrun", int'(usb_ready), 1);
          send_pkt(c, code + 7 * iso + 2 * ext, 0);
          chk("R5 set committed", int'(set_valid), 1);
          chk("R3 capacity count", int'(rd_count), c);
          read_pkt("R2 sweep data", c, code + 7 * iso + 2 * ext);
          cpu_rd_en = 1'b1; tick(); cpu_rd_en = 1'b0;
          chk("R2 read past count", int'(cpu_rd_data), last_byte);
          advance("R7 sweep advance");
          chk("R7 released", int'(set_valid), 0);
        end
      end
    end

    // 16-byte non-isochronous setting for directed cases
    cfg_iso = 1'b0; cfg_ext = 1'b0; cfg_size = 2'd0;
    do_reset();

    // R8 both sets full
    send_pkt(4, 1, 0);
    send_pkt(6, 2, 0);
    chk("R8 both valid", int'(set_valid), 3);
    chk("R8 not ready", int'(usb_ready), 0);
    send_pkt(3, 3, 0);
    chk("R8 packet ignored", int'(set_valid), 3);
    chk("R5 first count", int'(rd_count), 4);
    read_pkt("R5 order first", 4, 1);
    advance("R7 advance full");
    chk("R5 second count", int'(rd_count), 6);
    read_pkt("R8 second intact", 6, 2);
    advance("R7 advance second");
    chk("R8 drained", int'(set_valid), 0);

    // R6 rewind and retry
    send_pkt(5, 4, 1);
    chk("R6 nothing committed", int'(set_valid), 0);
    send_pkt(3, 5, 0);
    chk("R6 retry count", int'(rd_count), 3);
    read_pkt("R6 retry data", 3, 5);
    advance("R7 advance retry");

    // R10 zero-length packet
    send_pkt(0, 0, 0);
    chk("R10 valid", int'(set_valid != 2'b00), 1);
    chk("R10 count", int'(rd_count), 0);
    cpu_rd_en = 1'b1; tick(); cpu_rd_en = 1'b0;
    chk("R10 read ignored", int'(cpu_rd_data), last_byte);
    advance("R10 advance");
    chk("R10 released", int'(set_valid), 0);

    // R7 advance with nothing to release
    advance("R7 empty advance");
    chk("R7 empty unchanged", int'(set_valid), 0);
    send_pkt(2, 6, 0);
    read_pkt("R7 read set kept", 2, 6);
    advance("R7 after empty");

    // R9 manual mode
    cfg_manual = 1'b1;
    tick();
    send_pkt(3, 7, 0);
    chk("R9 pend_ok", int'(pend_ok), 1);
    chk("R9 no auto commit", int'(set_valid), 0);
    pulse_fw(1);
    chk("R9 fw commit", int'(set_valid != 2'b00), 1);
    chk("R9 pend cleared", int'({pend_ok, pend_err}), 0);
    chk("R9 count", int'(rd_count), 3);
    read_pkt("R9 data", 3, 7);
    advance("R9 advance");
    send_pkt(4, 8, 1);
    chk("R9 pend_err", int'(pend_err), 1);
    chk("R9 pend_ok low", int'(pend_ok), 0);
    pulse_fw(0);
    chk("R9 rewind clears", int'(pend_err), 0);
    chk("R9 rewind no set", int'(set_valid), 0);
    send_pkt(2, 9, 0);
    pulse_fw(1);
    chk("R9 retried count", int'(rd_count), 2);
    read_pkt("R9 retried data", 2, 9);
    advance("R9 advance 2");

    // R9 manual ignored on isochronous endpoint
    cfg_iso = 1'b1;
    do_reset();
    send_pkt(5, 10, 0);
    chk("R9 iso commits", int'(set_valid), 1);
    chk("R9 iso no pend", int'(pend_ok), 0);
    read_pkt("R9 iso data", 5, 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule